// File: doc/BRIEF.md
# Selective Write Mirror with One-Entry Posted Buffer

This block sits between a fast processor and two memories. One is the processor's private fast SRAM. The other is the slower host DRAM that a video controller scans. Every write the processor makes goes straight on to the fast SRAM port. A mirror-mode register, written by software, picks which address windows must also reach host memory. A write that falls in a selected window is copied into a single-entry posted buffer. The processor keeps running while that buffer drains over a request/acknowledge handshake.

The processor is held back only when a second mirrored write arrives while the buffer still holds an entry that the host has not yet acknowledged. If the acknowledge arrives in the same cycle as the waiting write, the old entry retires and the new one is captured at once, with no lost cycle. A mode change applies to writes issued after the register update. An entry already posted still drains.

Top module: `wmir_top`

## Requirements
- R1: A CPU write that is not stalled (cpu_we high, cpu_stall low) appears combinationally on sram_we/sram_addr/sram_wdata in the same cycle. While cpu_stall is high, sram_we is low.
- R2: cfg_we loads cfg_mode into the mode register at the clock edge, with the encoding 0 = none, 1 = text, 2 = graphics, 3 = all. A CPU write in the same cycle as cfg_we is decoded with the previous mode.
- R3: In text mode (1), only addresses 0x0400–0x07FF (text screen) and 0xD800–0xDBFF (color) are mirrored, bounds inclusive.
- R4: In graphics mode (2), only addresses 0xA000–0xBF3F (bitmap) and 0xD800–0xDBFF (color) are mirrored, bounds inclusive.
- R5: In all mode (3), every address of the 64 KB space is mirrored. In none mode (0), no write is mirrored.
- R6: An accepted mirrored write with the buffer empty does not stall. In the next cycle host_req is high, with host_addr/host_data equal to the written address/data.
- R7: While host_req is high and host_ack is low, host_req, host_addr and host_data hold. host_ack clears the entry by the next cycle. host_ack while host_req is low has no effect.
- R8: cpu_stall is high exactly when a mirrored write is presented while the buffer is full and host_ack is low. A non-mirrored write never stalls.
- R9: When host_ack arrives while a mirrored write is stalled, that write is accepted in the same cycle and is the next buffer entry.
- R10: A buffered entry still drains with its original address and data after the mode changes to one that would not mirror it.
- R11: After reset, host_req and cpu_stall are low and the mode is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mirror-mode register write strobe |
| cfg_mode | input | 2 | New mirror mode (0 none, 1 text, 2 graphics, 3 all) |
| cpu_we | input | 1 | CPU write request |
| cpu_addr | input | AW (16) | CPU write address |
| cpu_wdata | input | DW (8) | CPU write data |
| cpu_stall | output | 1 | Hold the CPU write: buffer full |
| sram_we | output | 1 | Fast SRAM write strobe |
| sram_addr | output | AW (16) | Fast SRAM write address |
| sram_wdata | output | DW (8) | Fast SRAM write data |
| host_req | output | 1 | Buffer holds an entry to be written to host memory |
| host_addr | output | AW (16) | Buffered host address |
| host_data | output | DW (8) | Buffered host data |
| host_ack | input | 1 | Host has taken the buffered entry |

## Verification
The bench builds the block with its default 16-bit address and 8-bit data and the default window bounds. This makes every window edge (first, last and the neighbour on each side) reachable with plain literal addresses. With the address width equal to the host space, the all-mode variant covers the full 0x0000–0xFFFF range, so both ends are probed. The one-entry depth lets the bench reach the full-buffer collision, the held stall and the same-cycle refill within a few cycles of a single posted write.

// File: rtl/wmir_pkg.sv
package wmir_pkg;

   typedef enum logic [1:0] {
      MIR_NONE = 2'd0,
      MIR_TEXT = 2'd1,
      MIR_GFX  = 2'd2,
      MIR_ALL  = 2'd3
   } mir_mode_e;

   localparam int unsigned NUM_WIN   = 3;
   localparam int unsigned WIN_TEXT  = 0;
   localparam int unsigned WIN_COLOR = 1;
   localparam int unsigned WIN_BMP   = 2;

   // Which address window is active under a given mirror mode.
   function automatic logic win_enabled(input mir_mode_e mode, input int unsigned idx);
      logic en;
      case (mode)
         MIR_TEXT: en = (idx == WIN_TEXT) || (idx == WIN_COLOR);
         MIR_GFX:  en = (idx == WIN_BMP)  || (idx == WIN_COLOR);
         default:  en = 1'b0;
      endcase
      return en;
   endfunction

endpackage

// File: rtl/wmir_mode_reg.sv
module wmir_mode_reg
   import wmir_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_we,
   input  logic [1:0] cfg_mode,
   output mir_mode_e mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MIR_NONE;
      end else if (cfg_we) begin
         mode_q <= mir_mode_e'(cfg_mode);
      end
   end

endmodule

// File: rtl/wmir_range_sel.sv
module wmir_range_sel
   import wmir_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned HOST_AW  = 16,
   parameter int unsigned TEXT_LO  = 32'h0400,
   parameter int unsigned TEXT_HI  = 32'h07FF,
   parameter int unsigned COLOR_LO = 32'hD800,
   parameter int unsigned COLOR_HI = 32'hDBFF,
   parameter int unsigned BMP_LO   = 32'hA000,
   parameter int unsigned BMP_HI   = 32'hBF3F
)(
   input  mir_mode_e        mode,
   input  logic [AW-1:0]    addr,
   output logic             hit
);

   localparam logic [AW-1:0] WIN_LO [NUM_WIN] = '{AW'(TEXT_LO), AW'(COLOR_LO), AW'(BMP_LO)};
   localparam logic [AW-1:0] WIN_HI [NUM_WIN] = '{AW'(TEXT_HI), AW'(COLOR_HI), AW'(BMP_HI)};

   if (TEXT_LO > TEXT_HI || COLOR_LO > COLOR_HI || BMP_LO > BMP_HI) begin : g_bad_win
      $error("wmir_range_sel: a window has its low bound above its high bound");
   end
   if (BMP_HI >= (32'd1 << HOST_AW) || TEXT_HI >= (32'd1 << HOST_AW) ||
       COLOR_HI >= (32'd1 << HOST_AW)) begin : g_bad_host
      $error("wmir_range_sel: a window lies outside the host address space");
   end

   logic [NUM_WIN-1:0] win_hit;
   logic               in_host;

   // Per-window comparators, each gated by the mode's window enable.
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      always_comb begin
         win_hit[w] = win_enabled(mode, w) &&
                      (addr >= WIN_LO[w]) && (addr <= WIN_HI[w]);
      end
   end

   // Variant: a CPU space wider than the host space only mirrors its low part.
   if (AW > HOST_AW) begin : g_wide
      assign in_host = ~|addr[AW-1:HOST_AW];
   end else begin : g_fit
      assign in_host = 1'b1;
   end

   assign hit = ((mode == MIR_ALL) && in_host) || (|win_hit);

endmodule

// File: rtl/wmir_post_buf.sv
module wmir_post_buf #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic          full,
   output logic [AW-1:0] ent_addr,
   output logic [DW-1:0] ent_data
);

   logic full_d;

   // A capture wins over retire: a same-cycle push refills the slot.
   always_comb begin
      if (push)
         full_d = 1'b1;
      else if (pop)
         full_d = 1'b0;
      else
         full_d = full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
      end else begin
         full <= full_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_addr <= '0;
         ent_data <= '0;
      end else if (push) begin
         ent_addr <= push_addr;
         ent_data <= push_data;
      end
   end

endmodule

// File: rtl/wmir_top.sv
module wmir_top
   import wmir_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned DW       = 8,
   parameter int unsigned HOST_AW  = 16,
   parameter int unsigned TEXT_LO  = 32'h0400,
   parameter int unsigned TEXT_HI  = 32'h07FF,
   parameter int unsigned COLOR_LO = 32'hD800,
   parameter int unsigned COLOR_HI = 32'hDBFF,
   parameter int unsigned BMP_LO   = 32'hA000,
   parameter int unsigned BMP_HI   = 32'hBF3F
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_mode,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_stall,
   output logic          sram_we,
   output logic [AW-1:0] sram_addr,
   output logic [DW-1:0] sram_wdata,
   output logic          host_req,
   output logic [AW-1:0] host_addr,
   output logic [DW-1:0] host_data,
   input  logic          host_ack
);

   if (AW < HOST_AW) begin : g_bad_aw
      $error("wmir_top: CPU address width must cover the host space");
   end
   if (DW < 1) begin : g_bad_dw
      $error("wmir_top: data width must be at least one bit");
   end

   mir_mode_e mode_q;
   logic      hit;
   logic      buf_full;
   logic      retire;
   logic      accept;
   logic      push;

   wmir_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_mode (cfg_mode),
      .mode_q   (mode_q)
   );

   wmir_range_sel #(
      .AW       (AW),
      .HOST_AW  (HOST_AW),
      .TEXT_LO  (TEXT_LO),
      .TEXT_HI  (TEXT_HI),
      .COLOR_LO (COLOR_LO),
      .COLOR_HI (COLOR_HI),
      .BMP_LO   (BMP_LO),
      .BMP_HI   (BMP_HI)
   ) u_sel (
      .mode (mode_q),
      .addr (cpu_addr),
      .hit  (hit)
   );

   // An acknowledge only counts while an entry is held.
   assign retire    = host_ack && buf_full;
   assign cpu_stall = cpu_we && hit && buf_full && !host_ack;
   assign accept    = cpu_we && !cpu_stall;
   assign push      = accept && hit;

   wmir_post_buf #(
      .AW (AW),
      .DW (DW)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (cpu_addr),
      .push_data (cpu_wdata),
      .pop       (retire),
      .full      (buf_full),
      .ent_addr  (host_addr),
      .ent_data  (host_data)
   );

   assign sram_we    = accept;
   assign sram_addr  = cpu_addr;
   assign sram_wdata = cpu_wdata;
   assign host_req   = buf_full;

endmodule

// File: rtl/wmir_chk.sv
module wmir_chk
   import wmir_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8
)(
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_we,
   input logic          cpu_stall,
   input logic          sram_we,
   input logic [AW-1:0] sram_addr,
   input logic [DW-1:0] sram_wdata,
   input logic          host_req,
   input logic          host_ack,
   input logic [AW-1:0] host_addr,
   input logic [DW-1:0] host_data,
   input logic          push,
   input mir_mode_e     mode_q
);

   // R8: a stall needs a held entry and no acknowledge
   a_r8_stall_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall |-> (host_req && !host_ack && cpu_we && !sram_we));

   // R7: the entry holds until acknowledged
   a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_ack) |=> (host_req && $stable(host_addr) && $stable(host_data)));

   // R7: an acknowledge without refill empties the buffer
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_ack && !push) |=> !host_req);

   // R6: a capture presents the written pair next cycle
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (host_req && host_addr == $past(sram_addr) && host_data == $past(sram_wdata)));

   // R5: none mode never posts
   a_r5_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MIR_NONE) |-> !push);

   // R11: the buffer starts empty after reset
   a_r11_reset_empty: assert property (@(posedge clk)
      $rose(rst_n) |-> !host_req);

endmodule

bind wmir_top wmir_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_we     (cpu_we),
   .cpu_stall  (cpu_stall),
   .sram_we    (sram_we),
   .sram_addr  (sram_addr),
   .sram_wdata (sram_wdata),
   .host_req   (host_req),
   .host_ack   (host_ack),
   .host_addr  (host_addr),
   .host_data  (host_data),
   .push       (push),
   .mode_q     (mode_q)
);

// File: tb/wmir_top_tb_top.sv
module wmir_top_tb_top;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int NV = 20;

   // {mode[1:0], addr[15:0], expect_mirror}
   localparam logic [18:0] VEC [NV] = '{
      {2'd1, 16'h03FF, 1'b0}, {2'd1, 16'h0400, 1'b1}, {2'd1, 16'h07FF, 1'b1},
      {2'd1, 16'h0800, 1'b0}, {2'd1, 16'hD7FF, 1'b0}, {2'd1, 16'hD800, 1'b1},
      {2'd1, 16'hDBFF, 1'b1}, {2'd1, 16'hDC00, 1'b0}, {2'd1, 16'hA000, 1'b0},
      {2'd2, 16'hA000, 1'b1}, {2'd2, 16'hBF3F, 1'b1}, {2'd2, 16'hBF40, 1'b0},
      {2'd2, 16'h9FFF, 1'b0}, {2'd2, 16'hDA00, 1'b1}, {2'd2, 16'h0500, 1'b0},
      {2'd3, 16'h0000, 1'b1}, {2'd3, 16'hFFFF, 1'b1}, {2'd3, 16'h3C5A, 1'b1},
      {2'd0, 16'hD800, 1'b0}, {2'd0, 16'h0400, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_mode = 2'd0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_stall;
   logic          sram_we;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] sram_wdata;
   logic          host_req;
   logic [AW-1:0] host_addr;
   logic [DW-1:0] host_data;
   logic          host_ack = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   wmir_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_mode   (cfg_mode),
      .cpu_we     (cpu_we),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .cpu_stall  (cpu_stall),
      .sram_we    (sram_we),
      .sram_addr  (sram_addr),
      .sram_wdata (sram_wdata),
      .host_req   (host_req),
      .host_addr  (host_addr),
      .host_data  (host_data),
      .host_ack   (host_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a negedge; leaves the bench at the following negedge.
   task automatic set_mode(input logic [1:0] m);
      cfg_we   = 1'b1;
      cfg_mode = m;
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   task automatic drain;
      host_ack = 1'b1;
      @(negedge clk);
      host_ack = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state, mode none
      chk("R11 host_req after reset", 32'(host_req), 32'd0);
      chk("R11 cpu_stall after reset", 32'(cpu_stall), 32'd0);
      cpu_we = 1'b1; cpu_addr = 16'h0400; cpu_wdata = 8'h11;
      #2 chk("R11 no stall in reset mode", 32'(cpu_stall), 32'd0);
      @(negedge clk);
      cpu_we = 1'b0;
      chk("R11 reset mode is none", 32'(host_req), 32'd0);

      // Table walk: R3 R4 R5 R6 R1
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  vm;
         logic [15:0] va;
         logic        vh;
         vm = VEC[i][18:17];
         va = VEC[i][16:1];
         vh = VEC[i][0];
         set_mode(vm);
         cpu_we = 1'b1; cpu_addr = va; cpu_wdata = 8'(i + 8'h40);
         #2;
         chk("R1 sram_we on write", 32'(sram_we), 32'd1);
         chk("R1 sram_addr", 32'(sram_addr), 32'(va));
         chk("R6 no stall when empty", 32'(cpu_stall), 32'd0);
         @(negedge clk);
         cpu_we = 1'b0;
         chk((vm == 2'd1) ? "R3 text window" : (vm == 2'd2) ? "R4 graphics window" : "R5 all/none",
             32'(host_req), 32'(vh));
         if (vh) begin
            chk("R6 host_addr", 32'(host_addr), 32'(va));
            chk("R6 host_data", 32'(host_data), 32'(i + 8'h40));
            drain();
            chk("R7 ack empties buffer", 32'(host_req), 32'd0);
         end
      end

      // R2: write in the cfg cycle uses the old mode (none -> all)
      set_mode(2'd0);
      cfg_we = 1'b1; cfg_mode = 2'd3;
      cpu_we = 1'b1; cpu_addr = 16'h1234; cpu_wdata = 8'hA5;
      @(negedge clk);
      cfg_we = 1'b0; cpu_we = 1'b0;
      chk("R2 same-cycle write uses old mode", 32'(host_req), 32'd0);
      cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0;
      chk("R2 new mode applies after update", 32'(host_req), 32'd1);

      // R7: hold for three cycles without ack
      repeat (3) begin
         @(negedge clk);
         chk("R7 hold req", 32'(host_req), 32'd1);
         chk("R7 hold addr", 32'(host_addr), 32'h1234);
      end
      drain();

      // R7: stray ack while empty has no effect
      host_ack = 1'b1;
      @(negedge clk);
      host_ack = 1'b0;
      chk("R7 stray ack keeps empty", 32'(host_req), 32'd0);
      cpu_we = 1'b1; cpu_addr = 16'h2222; cpu_wdata = 8'h5C;
      @(negedge clk);
      cpu_we = 1'b0;
      chk("R7 capture after stray ack", 32'(host_addr), 32'h2222);
      chk("R7 data after stray ack", 32'(host_data), 32'h5C);

      // R8 collision and R9 same-cycle refill (buffer holds 0x2222)
      cpu_we = 1'b1; cpu_addr = 16'h3333; cpu_wdata = 8'h77;
      #2;
      chk("R8 stall on full", 32'(cpu_stall), 32'd1);
      chk("R1 no sram write while stalled", 32'(sram_we), 32'd0);
      @(negedge clk);
      chk("R8 stall persists", 32'(cpu_stall), 32'd1);
      chk("R8 old entry held", 32'(host_addr), 32'h2222);
      host_ack = 1'b1;
      #2;
      chk("R9 stall released by ack", 32'(cpu_stall), 32'd0);
      chk("R9 sram write on release", 32'(sram_we), 32'd1);
      @(negedge clk);
      host_ack = 1'b0; cpu_we = 1'b0;
      chk("R9 refill req", 32'(host_req), 32'd1);
      chk("R9 refill addr", 32'(host_addr), 32'h3333);
      chk("R9 refill data", 32'(host_data), 32'h77);

      // R8: non-mirrored write while full does not stall (text mode)
      drain();
      set_mode(2'd1);
      cpu_we = 1'b1; cpu_addr = 16'h0410; cpu_wdata = 8'h01;
      @(negedge clk);
      cpu_addr = 16'h1000; cpu_wdata = 8'h02;
      #2;
      chk("R8 no stall for unmirrored", 32'(cpu_stall), 32'd0);
      chk("R8 unmirrored reaches sram", 32'(sram_we), 32'd1);
      @(negedge clk);
      cpu_we = 1'b0;
      chk("R8 entry unchanged", 32'(host_addr), 32'h0410);

      // R10: mode change to none keeps the posted entry
      set_mode(2'd0);
      chk("R10 entry survives mode change", 32'(host_req), 32'd1);
      chk("R10 entry addr kept", 32'(host_addr), 32'h0410);
      chk("R10 entry data kept", 32'(host_data), 32'h01);
      drain();
      chk("R10 entry drained", 32'(host_req), 32'd0);
      cpu_we = 1'b1; cpu_addr = 16'h0410;
      @(negedge clk);
      cpu_we = 1'b0;
      chk("R10 none mode after drain", 32'(host_req), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule